// File: doc/BRIEF.md
# Full-Bridge Audio Duty-Cycle Modulator

This block turns a stream of unsigned 12-bit audio samples into four switch-control signals for an H-bridge power stage. A free-running counter defines a switching period of 1024 clocks. At the start of each period the block raises a one-clock start-of-conversion strobe, which an external sampler uses to capture the next audio value. That value comes back on a valid-qualified sample input.

The block reduces the 12-bit sample to a 10-bit duty compare by keeping its ten most significant bits. It parks the compare in a shadow register and copies it to the active compare only when a new period begins, so a period's duty is never altered once the period has started. Half-bridge A follows the duty demand and half-bridge B follows its inverse, so current flows through the load on one diagonal at a time. A programmable dead time holds back every turn-on edge, so the two switches of one half-bridge are never both closed.

After reset the bridge stays fully off for the first period. It then runs at mid-scale duty, which gives zero differential drive, until samples arrive.

Top module: `bridge_pwm_mod`

## Requirements
- R1: The period counter runs 0 to 1023 and wraps. `soc_o` is high for exactly one clock at count 0 of every period. The first pulse comes 1024 clocks after reset release.
- R2: The compare value is `sample_i[11:2]`. `a_hi_o` (with zero dead time) is high in the cycles whose count is below the active compare. A compare of 0 gives no high cycles and a sample of 4095 gives 1023 high cycles.
- R3: A sample accepted during a period leaves that period's duty unchanged and takes effect at the next period start.
- R4: When several samples are accepted in one period, the last one is applied. This includes a sample accepted in the final cycle (count 1023).
- R5: During reset and until the first period start, all four leg outputs and `soc_o` are low. The compare values reset to 512, so the first running period has 512 high cycles on `a_hi_o`.
- R6: With zero dead time, `a_lo_o` is the exact complement of `a_hi_o` once running. No leg pair ever has both outputs high.
- R7: Half-bridge B is driven by the inverse demand: `b_hi_o` equals `a_lo_o` and `b_lo_o` equals `a_hi_o` once running. `a_hi_o` and `b_hi_o` are never both high, and `a_lo_o` and `b_lo_o` are never both high.
- R8: With `dead_cycles_i` = d (0 to 15), each leg turns on d clocks after its demand begins and turns off with its demand. At compare 512, each leg is then high for 512-d cycles per period and each half-bridge is fully off for 2d cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously to clk_i |
| sample_i | input | 12 | Unsigned audio sample |
| sample_valid_i | input | 1 | Sample strobe, one write per high cycle |
| dead_cycles_i | input | 4 | Turn-on delay in clocks |
| soc_o | output | 1 | Start-of-conversion pulse at period start |
| a_hi_o | output | 1 | Half-bridge A high-side switch |
| a_lo_o | output | 1 | Half-bridge A low-side switch |
| b_hi_o | output | 1 | Half-bridge B high-side switch |
| b_lo_o | output | 1 | Half-bridge B low-side switch |

## Verification
The bench builds the block with its default parameters: a 10-bit period counter, 12-bit samples and a 4-bit dead-time field. With these values a full 1024-clock period can be measured cycle by cycle. The duty extremes 0 and 1023, a sample write in the last cycle of a period, and the largest dead time of 15 clocks are all reached directly. Each scenario counts the high cycles of every leg over one whole aligned period and compares the counts with figures derived from the sample value and the dead time.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } leg_pair_t;
endpackage

// File: rtl/bpm_period_ctr.sv
module bpm_period_ctr #(
  parameter int PERIOD_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [PERIOD_W-1:0] cnt,
  output logic                boundary,
  output logic                soc,
  output logic                armed
);
  localparam logic [PERIOD_W-1:0] CNT_MAX = '1;

  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic                soc_q, soc_d;
  logic                armed_q, armed_d;

  always_comb begin
    boundary = (cnt_q == CNT_MAX);
    cnt_d    = boundary ? '0 : cnt_q + 1'b1;
    soc_d    = boundary;
    armed_d  = armed_q | boundary;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      soc_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      soc_q   <= soc_d;
      armed_q <= armed_d;
    end
  end

  assign cnt   = cnt_q;
  assign soc   = soc_q;
  assign armed = armed_q;
endmodule

// File: rtl/bpm_cmp_buf.sv
module bpm_cmp_buf #(
  parameter int PERIOD_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] wr_val,
  input  logic                wr_en,
  input  logic                boundary,
  output logic [PERIOD_W-1:0] active
);
  localparam logic [PERIOD_W-1:0] MID = PERIOD_W'(1) << (PERIOD_W - 1);

  logic [PERIOD_W-1:0] shadow_q, shadow_d;
  logic [PERIOD_W-1:0] active_q, active_d;

  always_comb begin
    shadow_d = wr_en ? wr_val : shadow_q;
    active_d = boundary ? shadow_d : active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= MID;
      active_q <= MID;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
    end
  end

  assign active = active_q;
endmodule

// File: rtl/bpm_deadband.sv
module bpm_deadband
  import bpm_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            demand,
  input  logic [DT_W-1:0] dt,
  output leg_pair_t       legs
);
  localparam logic [DT_W-1:0] AGE_MAX = '1;

  logic            prev_q, prev_d;
  logic [DT_W-1:0] age_q, age_d;
  logic            settled;

  always_comb begin
    if (demand == prev_q)
      age_d = (age_q == AGE_MAX) ? AGE_MAX : age_q + 1'b1;
    else
      age_d = '0;
    prev_d   = demand;
    settled  = (age_d >= dt);
    legs.hi  = en &  demand & settled;
    legs.lo  = en & ~demand & settled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      age_q  <= '0;
    end else begin
      prev_q <= prev_d;
      age_q  <= age_d;
    end
  end
endmodule

// File: rtl/bridge_pwm_mod.sv
module bridge_pwm_mod
  import bpm_pkg::*;
#(
  parameter int PERIOD_W = 10,
  parameter int SAMPLE_W = 12,
  parameter int DT_W     = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_valid_i,
  input  logic [DT_W-1:0]     dead_cycles_i,
  output logic                soc_o,
  output logic                a_hi_o,
  output logic                a_lo_o,
  output logic                b_hi_o,
  output logic                b_lo_o
);
  localparam int SHIFT = SAMPLE_W - PERIOD_W;

  logic [PERIOD_W-1:0] cnt_w;
  logic [PERIOD_W-1:0] active_w;
  logic [PERIOD_W-1:0] scaled_w;
  logic                boundary_w;
  logic                armed_w;
  logic                pwm_w;
  leg_pair_t           bridge_w [2];

  generate
    if (SHIFT > 0) begin : g_trunc
      logic unused_lsbs;
      assign unused_lsbs = ^sample_i[SHIFT-1:0];
      assign scaled_w    = sample_i[SAMPLE_W-1:SHIFT];
    end else begin : g_pass
      assign scaled_w = PERIOD_W'(sample_i);
    end
  endgenerate

  bpm_period_ctr #(.PERIOD_W(PERIOD_W)) ctr_i (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .cnt      (cnt_w),
    .boundary (boundary_w),
    .soc      (soc_o),
    .armed    (armed_w)
  );

  bpm_cmp_buf #(.PERIOD_W(PERIOD_W)) cmp_i (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .wr_val   (scaled_w),
    .wr_en    (sample_valid_i),
    .boundary (boundary_w),
    .active   (active_w)
  );

  assign pwm_w = (cnt_w < active_w);

  generate
    for (genvar g = 0; g < 2; g++) begin : g_bridge
      bpm_deadband #(.DT_W(DT_W)) db_i (
        .clk    (clk_i),
        .rst_n  (rst_ni),
        .en     (armed_w),
        .demand ((g == 0) ? pwm_w : ~pwm_w),
        .dt     (dead_cycles_i),
        .legs   (bridge_w[g])
      );
    end
  endgenerate

  assign a_hi_o = bridge_w[0].hi;
  assign a_lo_o = bridge_w[0].lo;
  assign b_hi_o = bridge_w[1].hi;
  assign b_lo_o = bridge_w[1].lo;
endmodule

// File: rtl/bridge_pwm_chk.sv
module bridge_pwm_chk #(
  parameter int PERIOD_W = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                soc,
  input logic                a_hi,
  input logic                a_lo,
  input logic                b_hi,
  input logic                b_lo,
  input logic [PERIOD_W-1:0] cnt,
  input logic [PERIOD_W-1:0] active
);
  logic seen_soc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_soc_q <= 1'b0;
    else if (soc) seen_soc_q <= 1'b1;
  end

  AST_SOC_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) soc |=> !soc);                 // R1
  AST_SOC_AT_ZERO:    assert property (@(posedge clk) disable iff (!rst_n) soc |-> (cnt == '0));          // R1
  AST_ZERO_DUTY:      assert property (@(posedge clk) disable iff (!rst_n) (active == '0) |-> !a_hi);     // R2
  AST_CMP_HELD:       assert property (@(posedge clk) disable iff (!rst_n) !soc |-> $stable(active));     // R3
  AST_SAFE_START:     assert property (@(posedge clk) disable iff (!rst_n)
                        (!seen_soc_q && !soc) |-> !(a_hi || a_lo || b_hi || b_lo));                      // R5
  AST_LEG_A_EXCL:     assert property (@(posedge clk) disable iff (!rst_n) !(a_hi && a_lo));              // R6
  AST_LEG_B_EXCL:     assert property (@(posedge clk) disable iff (!rst_n) !(b_hi && b_lo));              // R6
  AST_DIAG_HIGH:      assert property (@(posedge clk) disable iff (!rst_n) !(a_hi && b_hi));              // R7
  AST_DIAG_LOW:       assert property (@(posedge clk) disable iff (!rst_n) !(a_lo && b_lo));              // R7
endmodule

bind bridge_pwm_mod bridge_pwm_chk #(.PERIOD_W(PERIOD_W)) chk_i (
  .clk    (clk_i),
  .rst_n  (rst_ni),
  .soc    (soc_o),
  .a_hi   (a_hi_o),
  .a_lo   (a_lo_o),
  .b_hi   (b_hi_o),
  .b_lo   (b_lo_o),
  .cnt    (cnt_w),
  .active (active_w)
);

// File: tb/bridge_pwm_mod_tb_top.sv
module bridge_pwm_mod_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] sample;
  logic        valid;
  logic [3:0]  dead;
  logic        soc, a_hi, a_lo, b_hi, b_lo;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  int n_ahi, n_alo, n_bhi, n_blo, n_soc, n_ovl, n_cmp, n_bmis, n_offa, soc_first;
  int cur_cmp;

  always #4 clk = ~clk;

  bridge_pwm_mod dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .sample_i       (sample),
    .sample_valid_i (valid),
    .dead_cycles_i  (dead),
    .soc_o          (soc),
    .a_hi_o         (a_hi),
    .a_lo_o         (a_lo),
    .b_hi_o         (b_hi),
    .b_lo_o         (b_lo)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_soc();
    do begin
      @(negedge clk);
      valid = 1'b0;
    end while (!soc);
  endtask

  // Aligns to a period start and measures that whole period; up to two writes.
  task automatic run_period(input int w1_off, input int w1_val, input int w2_off, input int w2_val);
    wait_soc();
    n_ahi = 0; n_alo = 0; n_bhi = 0; n_blo = 0; n_soc = 0;
    n_ovl = 0; n_cmp = 0; n_bmis = 0; n_offa = 0; soc_first = soc;
    for (int i = 0; i < 1024; i++) begin
      if (i != 0) @(negedge clk);
      valid = 1'b0;
      n_ahi += a_hi; n_alo += a_lo; n_bhi += b_hi; n_blo += b_lo; n_soc += soc;
      if ((a_hi && a_lo) || (b_hi && b_lo) || (a_hi && b_hi) || (a_lo && b_lo)) n_ovl++;
      if (a_lo == a_hi) n_cmp++;
      if ((b_hi != a_lo) || (b_lo != a_hi)) n_bmis++;
      if (!a_hi && !a_lo) n_offa++;
      if (i == w1_off) begin valid = 1'b1; sample = 12'(w1_val); end
      if (i == w2_off) begin valid = 1'b1; sample = 12'(w2_val); end
    end
  endtask

  task automatic t_reset_first();
    int k = 0;
    int bad = 0;
    rst_n = 1'b0; valid = 1'b0; sample = '0; dead = '0;
    repeat (3) @(negedge clk);
    if (soc || a_hi || a_lo || b_hi || b_lo) bad++;
    chk("R5 outputs low in reset", bad, 0);
    rst_n = 1'b1;
    do begin
      @(negedge clk);
      k++;
      if (!soc && (a_hi || a_lo || b_hi || b_lo)) bad++;
    end while (!soc && k < 2000);
    chk("R1 first soc delay", k, 1024);
    chk("R5 legs off before first period", bad, 0);
    // measure the first running period in place: restart at this soc
    n_ahi = 0; n_alo = 0; n_soc = 0; n_cmp = 0; n_bmis = 0;
    for (int i = 0; i < 1024; i++) begin
      if (i != 0) @(negedge clk);
      n_ahi += a_hi; n_alo += a_lo; n_soc += soc;
      if (a_lo == a_hi) n_cmp++;
      if ((b_hi != a_lo) || (b_lo != a_hi)) n_bmis++;
    end
    chk("R5 reset compare 512", n_ahi, 512);
    chk("R1 one soc per period", n_soc, 1);
    chk("R6 complement", n_cmp, 0);
    chk("R7 bridge B inverse", n_bmis, 0);
    cur_cmp = 512;
  endtask

  task automatic t_duty(input int s);
    run_period(100, s, -1, 0);
    chk("R3 mid-period write ignored", n_ahi, cur_cmp);
    chk("R1 soc once at start", n_soc + soc_first, 2);
    run_period(-1, 0, -1, 0);
    chk("R2 duty from sample", n_ahi, s >> 2);
    chk("R6 low leg complement count", n_alo, 1024 - (s >> 2));
    chk("R6 complement", n_cmp, 0);
    chk("R7 bridge B inverse", n_bmis + n_ovl, 0);
    cur_cmp = s >> 2;
  endtask

  task automatic t_last_wins();
    run_period(20, 800, 900, 1204);
    chk("R3 current period held", n_ahi, cur_cmp);
    run_period(-1, 0, -1, 0);
    chk("R4 last of two writes", n_ahi, 301);
    run_period(1023, 1600, -1, 0);
    chk("R3 final-cycle write held", n_ahi, 301);
    run_period(-1, 0, -1, 0);
    chk("R4 write in cycle 1023 applied", n_ahi, 400);
    cur_cmp = 400;
  endtask

  task automatic t_dead(input int d);
    run_period(10, 2048, -1, 0);
    dead = 4'(d);
    run_period(-1, 0, -1, 0);
    chk("R8 a_hi with dead time", n_ahi, 512 - d);
    chk("R8 a_lo with dead time", n_alo, 512 - d);
    chk("R8 b legs with dead time", n_bhi + n_blo, 1024 - 2 * d);
    chk("R8 bridge A off cycles", n_offa, 2 * d);
    chk("R7 no shoot-through with dead time", n_ovl, 0);
    cur_cmp = 512;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset_first();
    t_duty(3000);
    t_duty(0);
    t_duty(4095);
    t_duty(1);
    t_duty(2051);
    t_last_wins();
    t_dead(4);
    t_dead(15);
    t_dead(0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule